// File: doc/BRIEF.md
# Operand Forwarding and Load-Use Interlock Unit

This unit sits between the decode stage and the execute stage of a five-stage in-order integer pipeline. Each cycle it looks at the two source register numbers and the opcode of the instruction in decode. It compares them with the destination register, opcode and valid flag of the instructions in execute, memory and write-back. From that comparison it picks, for each of the two operands, where the value comes from. The choices are the register file, the execute-stage ALU result, the execute-stage link address of a jump, the memory-stage result or load data, the write-back value, or a forced zero. The chosen values are captured into the operand registers that feed the execute stage.

A producer that writes a register is classed in one of two ways. An ALU or ALU-immediate producer in execute can be forwarded at once. A load, JAL or JALR producer in execute cannot use that ALU path. For a jump the link address is forwarded from its own path instead. Only a load in execute whose destination is a register that decode reads, other than x0, raises the stall. During that stall the decode instruction holds and a bubble enters execute. One cycle later the load sits in memory and its read data is forwarded from there.

Top module: `bypass_ctl`

## Requirements
- R1: Opcodes are the standard 7-bit RV32I major opcodes: ALU 0x33, ALU-immediate 0x13, load 0x03, store 0x23, branch 0x63, JAL 0x6F, JALR 0x67.
  - Source 1 is read by ALU, ALU-immediate, load, store, branch and JALR.
  - Source 2 is read only by ALU, store and branch.
  - An operand that is not read selects code 0 (register file) and never stalls.
- R2: If execute is valid with an ALU or ALU-immediate opcode, and its destination equals a read, nonzero source, that operand selects code 1 and receives the execute ALU result.
- R3: If execute is valid with JAL or JALR, and its destination equals a read, nonzero source, that operand selects code 2 and receives the execute link address. No stall is raised.
- R4: If execute is valid with a load opcode, and its destination equals a read, nonzero source of a valid decode instruction, `stall` is 1 in the same cycle. This applies to either source. The operand select shows code 0 meanwhile.
- R5: If the operand matches a valid writer in memory and no writer in execute, it selects code 4 with the load data when memory holds a load. Otherwise it selects code 3 with the memory result.
- R6: If the operand matches only a valid writer in write-back, it selects code 5 with the write-back value.
- R7: When several stages match, execute wins over memory, and memory wins over write-back.
- R8: A read source of x0 selects code 6, the operand value is 0, and no stall is raised, whatever the downstream destinations are.
- R9: Stores, branches, unknown opcodes and stages whose valid flag is low never match any source.
- R10: When decode is valid and not stalled, the next rising clock edge loads the selected values into `opnd_a`/`opnd_b` and sets `issue_valid` to 1.
- R11: When decode is invalid or stalled, the next edge clears `issue_valid` and leaves `opnd_a`/`opnd_b` unchanged.
- R12: While reset is asserted (active low, asynchronous), `issue_valid`, `opnd_a` and `opnd_b` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| d_valid | input | 1 | Decode instruction present |
| d_opcode | input | 7 | Decode major opcode |
| d_rs1 | input | RAW (5) | Decode source 1 number |
| d_rs2 | input | RAW (5) | Decode source 2 number |
| d_rf_rs1 | input | XLEN (32) | Register-file read value for source 1 |
| d_rf_rs2 | input | XLEN (32) | Register-file read value for source 2 |
| e_valid | input | 1 | Execute stage holds an instruction |
| e_opcode | input | 7 | Execute opcode |
| e_rd | input | RAW (5) | Execute destination |
| e_alu_y | input | XLEN (32) | Execute ALU result |
| e_link | input | XLEN (32) | Execute link address (PC+4) |
| m_valid | input | 1 | Memory stage holds an instruction |
| m_opcode | input | 7 | Memory opcode |
| m_rd | input | RAW (5) | Memory destination |
| m_result | input | XLEN (32) | Memory-stage ALU result or link |
| m_load_data | input | XLEN (32) | Memory read data |
| w_valid | input | 1 | Write-back stage holds an instruction |
| w_opcode | input | 7 | Write-back opcode |
| w_rd | input | RAW (5) | Write-back destination |
| w_wb_data | input | XLEN (32) | Write-back value |
| sel_a | output | 3 | Source code chosen for operand A |
| sel_b | output | 3 | Source code chosen for operand B |
| stall | output | 1 | Load-use interlock |
| opnd_a | output | XLEN (32) | Registered operand A for execute |
| opnd_b | output | XLEN (32) | Registered operand B for execute |
| issue_valid | output | 1 | Registered: an instruction entered execute |

## Verification
The bench pairs decode opcodes that read zero, one or two sources with a single producer in execute, memory or write-back. This separates the ALU path, the link path, memory result versus load data, and the write-back path. Patterns with the same destination in two or three stages at once expose the stage priority. Patterns with load producers on either source, and on an unread source, separate a real load-use interlock from a false one. Stores, branches, invalid stages, idle decode and x0 sources show that no match is made where none is due. A two-cycle stall-then-forward sequence shows that the held operands and the bubble are right.

// File: rtl/bypass_pkg.sv
package bypass_pkg;

    localparam int OPW = 7;

    localparam logic [OPW-1:0] OPC_ALU   = 7'h33;
    localparam logic [OPW-1:0] OPC_ALUI  = 7'h13;
    localparam logic [OPW-1:0] OPC_LOAD  = 7'h03;
    localparam logic [OPW-1:0] OPC_STORE = 7'h23;
    localparam logic [OPW-1:0] OPC_BR    = 7'h63;
    localparam logic [OPW-1:0] OPC_JAL   = 7'h6F;
    localparam logic [OPW-1:0] OPC_JALR  = 7'h67;

    typedef enum logic [2:0] {
        SRC_RF     = 3'd0,
        SRC_E_ALU  = 3'd1,
        SRC_E_LINK = 3'd2,
        SRC_M_RES  = 3'd3,
        SRC_M_LOAD = 3'd4,
        SRC_W      = 3'd5,
        SRC_ZERO   = 3'd6
    } src_e;

    // Per-opcode usage class
    typedef struct packed {
        logic reads1;
        logic reads2;
        logic wr_fast;   // result available from the ALU in execute
        logic wr_late;   // writes, but not from the execute ALU
        logic is_load;
    } opclass_t;

endpackage

// File: rtl/op_classify.sv
module op_classify
    import bypass_pkg::*;
(
    input  logic [OPW-1:0] op,
    output opclass_t       cls
);
    always_comb begin
        cls = '0;
        case (op)
            OPC_ALU:   begin cls.reads1 = 1'b1; cls.reads2 = 1'b1; cls.wr_fast = 1'b1; end
            OPC_ALUI:  begin cls.reads1 = 1'b1; cls.wr_fast = 1'b1; end
            OPC_LOAD:  begin cls.reads1 = 1'b1; cls.wr_late = 1'b1; cls.is_load = 1'b1; end
            OPC_STORE: begin cls.reads1 = 1'b1; cls.reads2 = 1'b1; end
            OPC_BR:    begin cls.reads1 = 1'b1; cls.reads2 = 1'b1; end
            OPC_JAL:   begin cls.wr_late = 1'b1; end
            OPC_JALR:  begin cls.reads1 = 1'b1; cls.wr_late = 1'b1; end
            default:   cls = '0;
        endcase
    end
endmodule

// File: rtl/operand_pick.sv
module operand_pick
    import bypass_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int RAW  = 5
) (
    input  logic            rd_en,
    input  logic [RAW-1:0]  rs,
    input  logic [XLEN-1:0] rf_val,
    input  logic            e_valid,
    input  opclass_t        e_cls,
    input  logic [RAW-1:0]  e_rd,
    input  logic [XLEN-1:0] e_alu_y,
    input  logic [XLEN-1:0] e_link,
    input  logic            m_valid,
    input  opclass_t        m_cls,
    input  logic [RAW-1:0]  m_rd,
    input  logic [XLEN-1:0] m_result,
    input  logic [XLEN-1:0] m_load_data,
    input  logic            w_valid,
    input  opclass_t        w_cls,
    input  logic [RAW-1:0]  w_rd,
    input  logic [XLEN-1:0] w_wb_data,
    output src_e            sel,
    output logic [XLEN-1:0] val,
    output logic            hazard
);
    logic e_hit, m_hit, w_hit;

    always_comb begin
        e_hit = e_valid && (e_rd == rs) && (e_cls.wr_fast || e_cls.wr_late);
        m_hit = m_valid && (m_rd == rs) && (m_cls.wr_fast || m_cls.wr_late);
        w_hit = w_valid && (w_rd == rs) && (w_cls.wr_fast || w_cls.wr_late);
    end

    // Youngest producer first; x0 is never forwarded
    always_comb begin
        sel    = SRC_RF;
        val    = rf_val;
        hazard = 1'b0;
        if (!rd_en) begin
            sel = SRC_RF;
            val = rf_val;
        end else if (rs == '0) begin
            sel = SRC_ZERO;
            val = '0;
        end else if (e_hit) begin
            if (e_cls.wr_fast) begin
                sel = SRC_E_ALU;
                val = e_alu_y;
            end else if (e_cls.is_load) begin
                hazard = 1'b1;
            end else begin
                sel = SRC_E_LINK;
                val = e_link;
            end
        end else if (m_hit) begin
            if (m_cls.is_load) begin
                sel = SRC_M_LOAD;
                val = m_load_data;
            end else begin
                sel = SRC_M_RES;
                val = m_result;
            end
        end else if (w_hit) begin
            sel = SRC_W;
            val = w_wb_data;
        end
    end
endmodule

// File: rtl/bypass_ctl.sv
module bypass_ctl
    import bypass_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int NREGS = 32,
    localparam int RAW  = $clog2(NREGS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            d_valid,
    input  logic [6:0]      d_opcode,
    input  logic [RAW-1:0]  d_rs1,
    input  logic [RAW-1:0]  d_rs2,
    input  logic [XLEN-1:0] d_rf_rs1,
    input  logic [XLEN-1:0] d_rf_rs2,
    input  logic            e_valid,
    input  logic [6:0]      e_opcode,
    input  logic [RAW-1:0]  e_rd,
    input  logic [XLEN-1:0] e_alu_y,
    input  logic [XLEN-1:0] e_link,
    input  logic            m_valid,
    input  logic [6:0]      m_opcode,
    input  logic [RAW-1:0]  m_rd,
    input  logic [XLEN-1:0] m_result,
    input  logic [XLEN-1:0] m_load_data,
    input  logic            w_valid,
    input  logic [6:0]      w_opcode,
    input  logic [RAW-1:0]  w_rd,
    input  logic [XLEN-1:0] w_wb_data,
    output logic [2:0]      sel_a,
    output logic [2:0]      sel_b,
    output logic            stall,
    output logic [XLEN-1:0] opnd_a,
    output logic [XLEN-1:0] opnd_b,
    output logic            issue_valid
);
    localparam int NSTG = 4;   // decode, execute, memory, write-back
    localparam int NOPN = 2;   // operands A and B

    logic [OPW-1:0] stg_op  [NSTG];
    opclass_t       stg_cls [NSTG];

    assign stg_op[0] = d_opcode;
    assign stg_op[1] = e_opcode;
    assign stg_op[2] = m_opcode;
    assign stg_op[3] = w_opcode;

    for (genvar s = 0; s < NSTG; s++) begin : g_cls
        op_classify u_cls (
            .op  (stg_op[s]),
            .cls (stg_cls[s])
        );
    end

    logic [RAW-1:0]  pk_rs  [NOPN];
    logic            pk_en  [NOPN];
    logic [XLEN-1:0] pk_rf  [NOPN];
    src_e            pk_sel [NOPN];
    logic [XLEN-1:0] pk_val [NOPN];
    logic [NOPN-1:0] pk_haz;

    assign pk_rs[0] = d_rs1;
    assign pk_rs[1] = d_rs2;
    assign pk_en[0] = stg_cls[0].reads1;
    assign pk_en[1] = stg_cls[0].reads2;
    assign pk_rf[0] = d_rf_rs1;
    assign pk_rf[1] = d_rf_rs2;

    for (genvar i = 0; i < NOPN; i++) begin : g_pick
        operand_pick #(.XLEN(XLEN), .RAW(RAW)) u_pick (
            .rd_en       (pk_en[i]),
            .rs          (pk_rs[i]),
            .rf_val      (pk_rf[i]),
            .e_valid     (e_valid),
            .e_cls       (stg_cls[1]),
            .e_rd        (e_rd),
            .e_alu_y     (e_alu_y),
            .e_link      (e_link),
            .m_valid     (m_valid),
            .m_cls       (stg_cls[2]),
            .m_rd        (m_rd),
            .m_result    (m_result),
            .m_load_data (m_load_data),
            .w_valid     (w_valid),
            .w_cls       (stg_cls[3]),
            .w_rd        (w_rd),
            .w_wb_data   (w_wb_data),
            .sel         (pk_sel[i]),
            .val         (pk_val[i]),
            .hazard      (pk_haz[i])
        );
    end

    assign stall = d_valid && (|pk_haz);
    assign sel_a = pk_sel[0];
    assign sel_b = pk_sel[1];

    typedef struct packed {
        logic            issue;
        logic [XLEN-1:0] a;
        logic [XLEN-1:0] b;
    } ex_in_t;

    ex_in_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.issue = d_valid && !stall;
        if (d_valid && !stall) begin
            st_d.a = pk_val[0];
            st_d.b = pk_val[1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign opnd_a      = st_q.a;
    assign opnd_b      = st_q.b;
    assign issue_valid = st_q.issue;

    // Checks
    assert_stall_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (e_valid && e_opcode == OPC_LOAD && d_valid));

    assert_ealu_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_a == SRC_E_ALU) |-> (e_valid && (e_opcode == OPC_ALU || e_opcode == OPC_ALUI)));

    assert_x0_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (d_rs1 == '0) |-> (sel_a == SRC_RF || sel_a == SRC_ZERO));

    assert_issue_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (d_valid && !stall) |=> issue_valid);

    assert_bubble_R11: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !issue_valid);

    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> ($stable(opnd_a) && $stable(opnd_b)));
endmodule

// File: tb/bypass_ctl_tb_top.sv
module bypass_ctl_tb_top;
    localparam logic [6:0] ALU = 7'h33, ALUI = 7'h13, LD = 7'h03, ST = 7'h23,
                           BR = 7'h63, JAL = 7'h6F, JALR = 7'h67, UNK = 7'h7F;
    localparam logic [31:0] V_RFA = 32'h1000_00A1, V_RFB = 32'h2000_00B2,
                            V_EALU = 32'h3000_0003, V_ELNK = 32'h4000_0004,
                            V_MRES = 32'h5000_0005, V_MLD = 32'h6000_0006,
                            V_W = 32'h7000_0007;

    typedef struct packed {
        logic dv; logic [6:0] dop; logic [4:0] rs1; logic [4:0] rs2;
        logic ev; logic [6:0] eop; logic [4:0] erd;
        logic mv; logic [6:0] mop; logic [4:0] mrd;
        logic wv; logic [6:0] wop; logic [4:0] wrd;
        logic [2:0] xa; logic [2:0] xb; logic xs; logic [7:0] req;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{1, ALU, 5, 6, 0, ALU, 5, 0, ALU, 5, 0, ALU, 5, 0, 0, 0, 8'd1},   // R1 nothing downstream
        '{1, ALU, 5, 6, 1, ALU, 5, 0, ALU, 0, 0, ALU, 0, 1, 0, 0, 8'd2},   // R2 ALU in E to A
        '{1, ALU, 5, 6, 1, ALUI,6, 0, ALU, 0, 0, ALU, 0, 0, 1, 0, 8'd2},   // R2 ALUI in E to B
        '{1, ALU, 5, 6, 1, JAL, 5, 0, ALU, 0, 0, ALU, 0, 2, 0, 0, 8'd3},   // R3 JAL link
        '{1, ALU, 7, 5, 1, JALR,5, 0, ALU, 0, 0, ALU, 0, 0, 2, 0, 8'd3},   // R3 JALR link on B
        '{1, ALU, 5, 6, 1, LD,  5, 0, ALU, 0, 0, ALU, 0, 0, 0, 1, 8'd4},   // R4 load-use rs1
        '{1, ST,  7, 6, 1, LD,  6, 0, ALU, 0, 0, ALU, 0, 0, 0, 1, 8'd4},   // R4 load-use rs2
        '{1, ALUI,5, 6, 1, LD,  6, 0, ALU, 0, 0, ALU, 0, 0, 0, 0, 8'd1},   // R1 rs2 unread, no stall
        '{1, ALU, 5, 6, 0, ALU, 0, 1, LD,  5, 0, ALU, 0, 4, 0, 0, 8'd5},   // R5 load in M
        '{1, ALU, 5, 6, 0, ALU, 0, 1, JALR,6, 0, ALU, 0, 0, 3, 0, 8'd5},   // R5 result in M
        '{1, ALU, 5, 6, 0, ALU, 0, 0, ALU, 0, 1, LD,  5, 5, 0, 0, 8'd6},   // R6 W
        '{1, ALU, 5, 6, 1, ALU, 5, 1, ALU, 5, 1, ALU, 5, 1, 0, 0, 8'd7},   // R7 E over M, W
        '{1, ALU, 5, 6, 0, ALU, 0, 1, ALU, 6, 1, ALU, 6, 0, 3, 0, 8'd7},   // R7 M over W
        '{1, ALU, 0, 6, 1, LD,  0, 1, ALU, 0, 1, ALU, 0, 6, 0, 0, 8'd8},   // R8 x0, no stall
        '{1, ST,  5, 6, 1, ST,  5, 1, BR,  6, 1, UNK, 5, 0, 0, 0, 8'd9},   // R9 non-writers
        '{1, ALU, 5, 6, 0, LD,  5, 0, ALU, 6, 0, ALU, 5, 0, 0, 0, 8'd9},   // R9 invalid stages
        '{1, JAL, 5, 6, 1, LD,  5, 0, ALU, 0, 0, ALU, 0, 0, 0, 0, 8'd1},   // R1 JAL reads none
        '{0, ALU, 5, 6, 1, LD,  5, 0, ALU, 0, 0, ALU, 0, 0, 0, 0, 8'd11},  // R11 idle decode
        '{1, BR,  5, 5, 1, ALU, 5, 0, ALU, 0, 0, ALU, 0, 1, 1, 0, 8'd2}    // R2 both operands
    };

    logic clk = 0, rst_n = 0;
    always #5 clk = ~clk;

    logic d_valid, e_valid, m_valid, w_valid;
    logic [6:0] d_opcode, e_opcode, m_opcode, w_opcode;
    logic [4:0] d_rs1, d_rs2, e_rd, m_rd, w_rd;
    logic [2:0] sel_a, sel_b;
    logic stall, issue_valid;
    logic [31:0] opnd_a, opnd_b;

    bypass_ctl dut_i (
        .clk(clk), .rst_n(rst_n),
        .d_valid(d_valid), .d_opcode(d_opcode), .d_rs1(d_rs1), .d_rs2(d_rs2),
        .d_rf_rs1(V_RFA), .d_rf_rs2(V_RFB),
        .e_valid(e_valid), .e_opcode(e_opcode), .e_rd(e_rd),
        .e_alu_y(V_EALU), .e_link(V_ELNK),
        .m_valid(m_valid), .m_opcode(m_opcode), .m_rd(m_rd),
        .m_result(V_MRES), .m_load_data(V_MLD),
        .w_valid(w_valid), .w_opcode(w_opcode), .w_rd(w_rd), .w_wb_data(V_W),
        .sel_a(sel_a), .sel_b(sel_b), .stall(stall),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .issue_valid(issue_valid)
    );

    int n_run = 0, n_fail = 0;
    logic [31:0] exp_a = 0, exp_b = 0;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] code_val(input logic [2:0] c, input bit is_a);
        case (c)
            3'd0: return is_a ? V_RFA : V_RFB;
            3'd1: return V_EALU;
            3'd2: return V_ELNK;
            3'd3: return V_MRES;
            3'd4: return V_MLD;
            3'd5: return V_W;
            default: return 32'h0;
        endcase
    endfunction

    task automatic drive(input vec_t v);
        d_valid = v.dv; d_opcode = v.dop; d_rs1 = v.rs1; d_rs2 = v.rs2;
        e_valid = v.ev; e_opcode = v.eop; e_rd = v.erd;
        m_valid = v.mv; m_opcode = v.mop; m_rd = v.mrd;
        w_valid = v.wv; w_opcode = v.wop; w_rd = v.wrd;
    endtask

    // Drive at falling edge, check selects, then the registered result after the rise
    task automatic run_vec(input vec_t v);
        string tag;
        bit go;
        tag = $sformatf("R%0d", v.req);
        @(negedge clk);
        drive(v);
        #1;
        chk(tag, "sel_a", {29'd0, sel_a}, {29'd0, v.xa});
        chk(tag, "sel_b", {29'd0, sel_b}, {29'd0, v.xb});
        chk(tag, "stall", {31'd0, stall}, {31'd0, v.xs});
        go = v.dv && !v.xs;
        if (go) begin
            exp_a = code_val(v.xa, 1'b1);
            exp_b = code_val(v.xb, 1'b0);
        end
        @(posedge clk);
        #1;
        chk(go ? "R10" : "R11", "issue_valid", {31'd0, issue_valid}, {31'd0, go});
        chk(go ? "R10" : "R11", "opnd_a", opnd_a, exp_a);
        chk(go ? "R10" : "R11", "opnd_b", opnd_b, exp_b);
    endtask

    initial begin
        #200000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        drive(VECS[0]);
        repeat (3) @(posedge clk);
        #1;
        // R12 reset values
        chk("R12", "issue_valid", {31'd0, issue_valid}, 32'd0);
        chk("R12", "opnd_a", opnd_a, 32'd0);
        chk("R12", "opnd_b", opnd_b, 32'd0);
        @(negedge clk);
        rst_n = 1;

        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R4/R5/R11 directed: load-use stall then forward from memory one cycle later
        run_vec('{1, ALU, 9, 0, 1, ALU, 9, 0, ALU, 0, 0, ALU, 0, 1, 6, 0, 8'd2});
        run_vec('{1, ALU, 9, 4, 1, LD, 9, 0, ALU, 0, 0, ALU, 0, 0, 0, 1, 8'd4});
        run_vec('{1, ALU, 9, 4, 0, ALU, 0, 1, LD, 9, 0, ALU, 0, 4, 0, 0, 8'd5});
        // R8 x0 on B while ALU in E writes x0
        run_vec('{1, ALU, 3, 0, 1, ALU, 0, 0, ALU, 0, 0, ALU, 0, 0, 6, 0, 8'd8});

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule